// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Unit

This block keeps the machine-level control and status state of a 32-bit processor core. That state is the global interrupt enable and its saved copy, the saved privilege, the interrupt enables, the pending-interrupt view, the trap vector, the trap cause and the exception return address. It also holds the current privilege level. The pipeline presents one CSR access per cycle as an operation code, a 12-bit CSR address, a register operand with a flag that says the source register index is zero, and a 5-bit immediate. The unit returns the CSR's old value in the same cycle and commits the update at the next clock edge.

The unit also takes trap requests, each with a cause word and the faulting PC, and return-from-trap requests. For either request it raises a redirect strobe and a redirect PC in the same cycle, and it updates the saved state at the next edge. Trap targets can be direct or vectored. Only interrupts are spread across the vector table.

Top module: `mcsr_unit`

## Requirements
- R1: CSR operations are encoded on `csr_op` as 001 write, 010 set, 011 clear (register operand), and 101 write, 110 set, 111 clear (zero-extended `uimm` operand). 000 and 100 do nothing. `csr_rdata` shows the old value of the addressed CSR in the same cycle, and the new value is visible from the next cycle. Set ORs the operand in and clear removes the operand's bits. Addresses are 0x300 status, 0x304 enable, 0x305 vector, 0x341 return PC, 0x342 cause, 0x344 pending. Only bits 3, 7 and 11 of the enable register are writable. The return PC reads with bits 1:0 zero.
- R2: A register-operand set or clear with `rs_is_x0` high reads the CSR but leaves it unchanged, whatever `rs_val` holds.
- R3: An immediate set or clear with `uimm` equal to zero reads the CSR but leaves it unchanged.
- R4: A write (register or immediate form) whose operand is zero still writes, which clears the CSR.
- R5: On trap entry the aligned trap PC goes to the return-PC register and `trap_cause` goes to the cause register. The current privilege goes to status bits 12:11, status bit 3 is copied to bit 7, bit 3 is cleared, and privilege becomes machine (11).
- R6: The trap target is the vector register with bits 1:0 cleared. When vector bits 1:0 are 01 and `trap_cause` bit 31 is set, the target is that base plus 4 times `trap_cause[30:0]`. `redirect_valid` and `redirect_pc` are driven combinationally in the request cycle.
- R7: On return, status bit 3 takes the old bit 7, bit 7 becomes 1, privilege takes the old bits 12:11, bits 12:11 become user (00), and `redirect_pc` equals the return-PC register.
- R8: The pending register reads `irq_sw` at bit 3, `irq_tmr` at bit 7 and `irq_ext` at bit 11, and CSR writes to it have no effect.
- R9: A trap request takes precedence over a return request and over a CSR write in the same cycle. A return request takes precedence over a CSR write.
- R10: After reset, privilege is machine (11) and every stored CSR reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_op | input | 3 | CSR operation code |
| csr_addr | input | 12 | CSR address |
| rs_val | input | XLEN | Register operand value |
| rs_is_x0 | input | 1 | Source register index is zero |
| uimm | input | 5 | Immediate operand |
| trap_req | input | 1 | Trap entry request |
| trap_cause | input | XLEN | Cause word, bit XLEN-1 marks an interrupt |
| trap_pc | input | XLEN | PC of the trapping instruction |
| ret_req | input | 1 | Return-from-trap request |
| irq_sw | input | 1 | Software interrupt pending |
| irq_tmr | input | 1 | Timer interrupt pending |
| irq_ext | input | 1 | External interrupt pending |
| csr_rdata | output | XLEN | Old value of the addressed CSR |
| redirect_valid | output | 1 | PC redirect this cycle |
| redirect_pc | output | XLEN | Trap target or return PC |
| priv_mode | output | 2 | Current privilege (00 user, 11 machine) |

## Verification
On every cycle the assertions check the state saved by trap entry and restored by return, and the privilege change each one makes. They also check that a set or clear of the enable register with a zero operand field leaves it unchanged, that a trap outranks a return, and that the return redirect equals the saved PC. The directed scenarios are the only place that shows the arithmetic of vectored targets, the difference between direct and vectored modes, the bit masking of each register, the pending inputs seen through reads, and the ordering of several traps and returns in sequence.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
    localparam logic [11:0] A_MSTATUS = 12'h300;
    localparam logic [11:0] A_MIE     = 12'h304;
    localparam logic [11:0] A_MTVEC   = 12'h305;
    localparam logic [11:0] A_MEPC    = 12'h341;
    localparam logic [11:0] A_MCAUSE  = 12'h342;
    localparam logic [11:0] A_MIP     = 12'h344;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_M = 2'b11;

    localparam int ST_IE    = 3;
    localparam int ST_PIE   = 7;
    localparam int ST_PP_LO = 11;

    localparam int IRQ_SW_BIT  = 3;
    localparam int IRQ_TMR_BIT = 7;
    localparam int IRQ_EXT_BIT = 11;

    localparam int IMM_W = 5;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_SET   = 2'b10,
        KIND_CLEAR = 2'b11
    } op_kind_e;
endpackage

// File: rtl/mcsr_opcalc.sv
module mcsr_opcalc
    import mcsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [2:0]       op,
    input  logic [XLEN-1:0]  old_val,
    input  logic [XLEN-1:0]  rs_val,
    input  logic             rs_is_x0,
    input  logic [IMM_W-1:0] uimm,
    output logic             wr_en,
    output logic [XLEN-1:0]  wr_val
);
    logic [XLEN-1:0] operand;
    logic            field_zero;
    op_kind_e        kind;

    always_comb begin
        kind       = op_kind_e'(op[1:0]);
        operand    = op[2] ? {{(XLEN-IMM_W){1'b0}}, uimm} : rs_val;
        field_zero = op[2] ? (uimm == '0) : rs_is_x0;
        wr_en      = 1'b0;
        wr_val     = old_val;
        case (kind)
            KIND_WRITE: begin
                wr_en  = 1'b1;
                wr_val = operand;
            end
            KIND_SET: begin
                wr_en  = !field_zero;
                wr_val = old_val | operand;
            end
            KIND_CLEAR: begin
                wr_en  = !field_zero;
                wr_val = old_val & ~operand;
            end
            default: begin
                wr_en  = 1'b0;
                wr_val = old_val;
            end
        endcase
    end
endmodule

// File: rtl/mcsr_target.sv
module mcsr_target #(
    parameter int XLEN     = 32,
    parameter bit VECTORED = 1'b1
) (
    input  logic            trap_req,
    input  logic            ret_req,
    input  logic [XLEN-1:0] trap_cause,
    input  logic [XLEN-3:0] tvec_base,
    input  logic            tvec_vec,
    input  logic [XLEN-1:0] epc,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc
);
    logic [XLEN-1:0] base_pc;
    logic [XLEN-1:0] trap_tgt;

    assign base_pc = {tvec_base, 2'b00};

    generate
        if (VECTORED) begin : g_vec
            logic [XLEN-1:0] offset;
            assign offset   = {1'b0, trap_cause[XLEN-2:0]} << 2;
            assign trap_tgt = (tvec_vec && trap_cause[XLEN-1]) ? base_pc + offset : base_pc;
        end else begin : g_direct
            assign trap_tgt = base_pc;
        end
    endgenerate

    always_comb begin
        redirect_valid = trap_req | ret_req;
        if (trap_req)
            redirect_pc = trap_tgt;
        else if (ret_req)
            redirect_pc = epc;
        else
            redirect_pc = '0;
    end
endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
    import mcsr_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter bit VECTORED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       csr_op,
    input  logic [11:0]      csr_addr,
    input  logic [XLEN-1:0]  rs_val,
    input  logic             rs_is_x0,
    input  logic [4:0]       uimm,
    input  logic             trap_req,
    input  logic [XLEN-1:0]  trap_cause,
    input  logic [XLEN-1:0]  trap_pc,
    input  logic             ret_req,
    input  logic             irq_sw,
    input  logic             irq_tmr,
    input  logic             irq_ext,
    output logic [XLEN-1:0]  csr_rdata,
    output logic             redirect_valid,
    output logic [XLEN-1:0]  redirect_pc,
    output logic [1:0]       priv_mode
);
    localparam logic [XLEN-1:0] IE_MASK =
        (XLEN'(1) << IRQ_SW_BIT) | (XLEN'(1) << IRQ_TMR_BIT) | (XLEN'(1) << IRQ_EXT_BIT);

    typedef struct packed {
        logic            ie;
        logic            pie;
        logic [1:0]      pp;
        logic [XLEN-1:0] irq_en;
        logic [XLEN-3:0] tvec_base;
        logic            tvec_vec;
        logic [XLEN-3:0] epc;
        logic [XLEN-1:0] cause;
        logic [1:0]      priv;
    } state_t;

    state_t st_d, st_q;

    logic            wr_en;
    logic [XLEN-1:0] wr_val;
    logic [XLEN-1:0] status_view;
    logic [XLEN-1:0] pend_view;

    // Observation points for the bound checker
    logic            status_ie, status_pie;
    logic [1:0]      status_pp, cur_priv;
    logic [XLEN-1:0] epc_q, irq_en_q;

    assign status_ie  = st_q.ie;
    assign status_pie = st_q.pie;
    assign status_pp  = st_q.pp;
    assign cur_priv   = st_q.priv;
    assign epc_q      = {st_q.epc, 2'b00};
    assign irq_en_q   = st_q.irq_en;
    assign priv_mode  = st_q.priv;

    // Read view of the addressed CSR
    always_comb begin
        status_view = '0;
        status_view[ST_IE]                = st_q.ie;
        status_view[ST_PIE]               = st_q.pie;
        status_view[ST_PP_LO+1:ST_PP_LO]  = st_q.pp;
        pend_view = '0;
        pend_view[IRQ_SW_BIT]  = irq_sw;
        pend_view[IRQ_TMR_BIT] = irq_tmr;
        pend_view[IRQ_EXT_BIT] = irq_ext;
        case (csr_addr)
            A_MSTATUS: csr_rdata = status_view;
            A_MIE:     csr_rdata = st_q.irq_en;
            A_MTVEC:   csr_rdata = {st_q.tvec_base, 1'b0, st_q.tvec_vec};
            A_MEPC:    csr_rdata = {st_q.epc, 2'b00};
            A_MCAUSE:  csr_rdata = st_q.cause;
            A_MIP:     csr_rdata = pend_view;
            default:   csr_rdata = '0;
        endcase
    end

    mcsr_opcalc #(.XLEN(XLEN)) u_opcalc (
        .op       (csr_op),
        .old_val  (csr_rdata),
        .rs_val   (rs_val),
        .rs_is_x0 (rs_is_x0),
        .uimm     (uimm),
        .wr_en    (wr_en),
        .wr_val   (wr_val)
    );

    mcsr_target #(.XLEN(XLEN), .VECTORED(VECTORED)) u_target (
        .trap_req       (trap_req),
        .ret_req        (ret_req),
        .trap_cause     (trap_cause),
        .tvec_base      (st_q.tvec_base),
        .tvec_vec       (st_q.tvec_vec),
        .epc            ({st_q.epc, 2'b00}),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    // Next-state: trap entry, then return, then CSR write
    always_comb begin
        st_d = st_q;
        if (trap_req) begin
            st_d.epc   = trap_pc[XLEN-1:2];
            st_d.cause = trap_cause;
            st_d.pp    = st_q.priv;
            st_d.pie   = st_q.ie;
            st_d.ie    = 1'b0;
            st_d.priv  = PRIV_M;
        end else if (ret_req) begin
            st_d.ie   = st_q.pie;
            st_d.pie  = 1'b1;
            st_d.priv = st_q.pp;
            st_d.pp   = PRIV_U;
        end else if (wr_en) begin
            case (csr_addr)
                A_MSTATUS: begin
                    st_d.ie  = wr_val[ST_IE];
                    st_d.pie = wr_val[ST_PIE];
                    st_d.pp  = wr_val[ST_PP_LO+1:ST_PP_LO];
                end
                A_MIE:    st_d.irq_en = wr_val & IE_MASK;
                A_MTVEC: begin
                    st_d.tvec_base = wr_val[XLEN-1:2];
                    st_d.tvec_vec  = (wr_val[1:0] == 2'b01);
                end
                A_MEPC:   st_d.epc   = wr_val[XLEN-1:2];
                A_MCAUSE: st_d.cause = wr_val;
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.priv <= PRIV_M;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mcsr_unit_chk.sv
module mcsr_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      csr_op,
    input logic [11:0]     csr_addr,
    input logic            rs_is_x0,
    input logic [4:0]      uimm,
    input logic            trap_req,
    input logic [XLEN-1:0] trap_pc,
    input logic            ret_req,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc,
    input logic            status_ie,
    input logic            status_pie,
    input logic [1:0]      status_pp,
    input logic [1:0]      cur_priv,
    input logic [XLEN-1:0] epc_q,
    input logic [XLEN-1:0] irq_en_q
);
    p_trap_epc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> epc_q == {$past(trap_pc[XLEN-1:2]), 2'b00});

    p_trap_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (!status_ie && status_pie == $past(status_ie)
                      && status_pp == $past(cur_priv) && cur_priv == 2'b11));

    p_trap_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (redirect_valid && redirect_pc[1:0] == 2'b00));

    p_ret_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !trap_req) |=> (cur_priv == $past(status_pp) && status_pp == 2'b00
                                   && status_pie && status_ie == $past(status_pie)));

    p_ret_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !trap_req) |-> (redirect_valid && redirect_pc == epc_q));

    p_reg_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req && !ret_req && csr_addr == 12'h304 && rs_is_x0
         && (csr_op == 3'b010 || csr_op == 3'b011)) |=> $stable(irq_en_q));

    p_imm_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req && !ret_req && csr_addr == 12'h304 && uimm == 5'd0
         && (csr_op == 3'b110 || csr_op == 3'b111)) |=> $stable(irq_en_q));

    p_trap_over_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && ret_req) |=> cur_priv == 2'b11);
endmodule

bind mcsr_unit mcsr_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .csr_op         (csr_op),
    .csr_addr       (csr_addr),
    .rs_is_x0       (rs_is_x0),
    .uimm           (uimm),
    .trap_req       (trap_req),
    .trap_pc        (trap_pc),
    .ret_req        (ret_req),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .status_ie      (status_ie),
    .status_pie     (status_pie),
    .status_pp      (status_pp),
    .cur_priv       (cur_priv),
    .epc_q          (epc_q),
    .irq_en_q       (irq_en_q)
);

// File: tb/sim_mcsr_unit.sv
module sim_mcsr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  csr_op = '0;
    logic [11:0] csr_addr = '0;
    logic [31:0] rs_val = '0;
    logic        rs_is_x0 = 1'b0;
    logic [4:0]  uimm = '0;
    logic        trap_req = 1'b0;
    logic [31:0] trap_cause = '0;
    logic [31:0] trap_pc = '0;
    logic        ret_req = 1'b0;
    logic        irq_sw = 1'b0, irq_tmr = 1'b0, irq_ext = 1'b0;
    logic [31:0] csr_rdata;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic [1:0]  priv_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [11:0] STA = 12'h300, IEN = 12'h304, VEC = 12'h305,
                            EPC = 12'h341, CAU = 12'h342, PND = 12'h344;

    always #4 clk = ~clk;

    mcsr_unit u0 (
        .clk(clk), .rst_n(rst_n), .csr_op(csr_op), .csr_addr(csr_addr),
        .rs_val(rs_val), .rs_is_x0(rs_is_x0), .uimm(uimm),
        .trap_req(trap_req), .trap_cause(trap_cause), .trap_pc(trap_pc),
        .ret_req(ret_req), .irq_sw(irq_sw), .irq_tmr(irq_tmr), .irq_ext(irq_ext),
        .csr_rdata(csr_rdata), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .priv_mode(priv_mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic csr_do(input logic [2:0] op, input logic [11:0] a, input logic [31:0] v,
                          input logic x0, input logic [4:0] im, output logic [31:0] old);
        @(negedge clk);
        csr_op = op; csr_addr = a; rs_val = v; rs_is_x0 = x0; uimm = im;
        #1 old = csr_rdata;
        @(posedge clk);
        #1 csr_op = 3'b000; rs_is_x0 = 1'b0; rs_val = '0; uimm = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        csr_op = 3'b000; csr_addr = a;
        #1 v = csr_rdata;
    endtask

    task automatic do_trap(input logic [31:0] cause, input logic [31:0] pc, input logic with_ret,
                           output logic [31:0] tgt, output logic vld);
        @(negedge clk);
        trap_req = 1'b1; trap_cause = cause; trap_pc = pc; ret_req = with_ret;
        #1 tgt = redirect_pc; vld = redirect_valid;
        @(posedge clk);
        #1 trap_req = 1'b0; ret_req = 1'b0; csr_op = 3'b000;
    endtask

    task automatic do_ret(output logic [31:0] tgt, output logic vld);
        @(negedge clk);
        ret_req = 1'b1;
        #1 tgt = redirect_pc; vld = redirect_valid;
        @(posedge clk);
        #1 ret_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R10 priv", {30'd0, priv_mode}, 32'h3);
        rd(STA, v); chk("R10 status", v, 32'h0);
        rd(IEN, v); chk("R10 enable", v, 32'h0);
        rd(VEC, v); chk("R10 vector", v, 32'h0);
        rd(EPC, v); chk("R10 epc", v, 32'h0);
        rd(CAU, v); chk("R10 cause", v, 32'h0);
    endtask

    task automatic t_ops();
        logic [31:0] o, v;
        csr_do(3'b001, IEN, 32'hFFFF_FFFF, 1'b0, 5'd0, o);
        chk("R1 write old", o, 32'h0);
        rd(IEN, v); chk("R1 write masked", v, 32'h888);
        csr_do(3'b011, IEN, 32'h8, 1'b0, 5'd0, o);
        chk("R1 clear old", o, 32'h888);
        rd(IEN, v); chk("R1 clear", v, 32'h880);
        csr_do(3'b010, IEN, 32'h8, 1'b0, 5'd0, o);
        rd(IEN, v); chk("R1 set", v, 32'h888);
        csr_do(3'b101, CAU, 32'h0, 1'b0, 5'd5, o);
        rd(CAU, v); chk("R1 imm write", v, 32'h5);
        csr_do(3'b110, CAU, 32'h0, 1'b0, 5'd2, o);
        rd(CAU, v); chk("R1 imm set", v, 32'h7);
        csr_do(3'b111, CAU, 32'h0, 1'b0, 5'd1, o);
        chk("R1 imm clear old", o, 32'h7);
        rd(CAU, v); chk("R1 imm clear", v, 32'h6);
        csr_do(3'b001, EPC, 32'h1237, 1'b0, 5'd0, o);
        rd(EPC, v); chk("R1 epc align", v, 32'h1234);
    endtask

    task automatic t_zero_field();
        logic [31:0] o, v;
        csr_do(3'b011, IEN, 32'h888, 1'b1, 5'd0, o);
        chk("R2 clear x0 old", o, 32'h888);
        rd(IEN, v); chk("R2 clear x0 no write", v, 32'h888);
        csr_do(3'b011, IEN, 32'h8, 1'b0, 5'd0, o);
        csr_do(3'b010, IEN, 32'h8, 1'b1, 5'd0, o);
        rd(IEN, v); chk("R2 set x0 no write", v, 32'h880);
        csr_do(3'b110, CAU, 32'hFFFF_FFFF, 1'b0, 5'd0, o);
        rd(CAU, v); chk("R3 imm set zero", v, 32'h6);
        csr_do(3'b111, CAU, 32'hFFFF_FFFF, 1'b0, 5'd0, o);
        rd(CAU, v); chk("R3 imm clear zero", v, 32'h6);
        csr_do(3'b001, IEN, 32'h0, 1'b1, 5'd0, o);
        rd(IEN, v); chk("R4 write x0 clears", v, 32'h0);
        csr_do(3'b101, CAU, 32'h0, 1'b0, 5'd0, o);
        rd(CAU, v); chk("R4 imm write zero clears", v, 32'h0);
    endtask

    task automatic t_pending();
        logic [31:0] o, v;
        @(negedge clk); irq_sw = 1'b1; irq_ext = 1'b1; irq_tmr = 1'b0;
        rd(PND, v); chk("R8 sw+ext", v, 32'h808);
        csr_do(3'b001, PND, 32'hFFFF_FFFF, 1'b0, 5'd0, o);
        chk("R8 write old", o, 32'h808);
        @(negedge clk); irq_sw = 1'b0; irq_ext = 1'b0; irq_tmr = 1'b1;
        rd(PND, v); chk("R8 write ignored", v, 32'h80);
        @(negedge clk); irq_tmr = 1'b0;
    endtask

    task automatic t_trap();
        logic [31:0] o, v, tgt;
        logic vld;
        csr_do(3'b001, VEC, 32'h1001, 1'b0, 5'd0, o);
        csr_do(3'b110, STA, 32'h0, 1'b0, 5'd8, o);
        do_trap(32'h8000_0007, 32'h2000_0042, 1'b0, tgt, vld);
        chk("R6 valid", {31'd0, vld}, 32'h1);
        chk("R6 vectored irq", tgt, 32'h101C);
        rd(EPC, v); chk("R5 epc", v, 32'h2000_0040);
        rd(CAU, v); chk("R5 cause", v, 32'h8000_0007);
        rd(STA, v); chk("R5 status", v, 32'h1880);
        do_trap(32'h2, 32'h300, 1'b0, tgt, vld);
        chk("R6 exception to base", tgt, 32'h1000);
        rd(STA, v); chk("R5 status second", v, 32'h1800);
        csr_do(3'b001, VEC, 32'h2000, 1'b0, 5'd0, o);
        do_trap(32'h8000_000B, 32'h4004, 1'b0, tgt, vld);
        chk("R6 direct irq", tgt, 32'h2000);
    endtask

    task automatic t_return();
        logic [31:0] o, v, tgt;
        logic vld;
        csr_do(3'b001, STA, 32'h80, 1'b0, 5'd0, o);
        do_ret(tgt, vld);
        chk("R7 valid", {31'd0, vld}, 32'h1);
        chk("R7 pc", tgt, 32'h4004);
        rd(STA, v); chk("R7 status", v, 32'h88);
        chk("R7 priv user", {30'd0, priv_mode}, 32'h0);
        do_trap(32'h3, 32'h5000, 1'b0, tgt, vld);
        rd(STA, v); chk("R5 from user status", v, 32'h80);
        chk("R5 priv machine", {30'd0, priv_mode}, 32'h3);
        csr_do(3'b001, STA, 32'h1800, 1'b0, 5'd0, o);
        do_ret(tgt, vld);
        chk("R7 pc second", tgt, 32'h5000);
        rd(STA, v); chk("R7 status from M", v, 32'h80);
        chk("R7 priv stays M", {30'd0, priv_mode}, 32'h3);
    endtask

    task automatic t_precedence();
        logic [31:0] o, v, tgt;
        logic vld;
        @(negedge clk);
        csr_op = 3'b001; csr_addr = EPC; rs_val = 32'h1234;
        do_trap(32'h5, 32'h6000, 1'b0, tgt, vld);
        rd(EPC, v); chk("R9 trap over csr write", v, 32'h6000);
        rd(CAU, v); chk("R9 cause from trap", v, 32'h5);
        csr_do(3'b001, STA, 32'h80, 1'b0, 5'd0, o);
        do_ret(tgt, vld);
        chk("R9 setup user", {30'd0, priv_mode}, 32'h0);
        do_trap(32'h1, 32'h7000, 1'b1, tgt, vld);
        chk("R9 trap target wins", tgt, 32'h2000);
        chk("R9 priv after trap+ret", {30'd0, priv_mode}, 32'h3);
        rd(STA, v); chk("R9 status after trap+ret", v, 32'h80);
        rd(EPC, v); chk("R9 epc after trap+ret", v, 32'h7000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_ops();
        t_zero_field();
        t_pending();
        t_trap();
        t_return();
        t_precedence();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule